// File: doc/BRIEF.md
# Double-Rate Burst-of-Four Static Memory

This block is a small synchronous memory with one read data port and one write data port, built so that a read burst and a write burst can be in progress in the same cycles. Every accepted address moves a burst of four words. An internal counter steps through the four words from the one address, so the address bus is free for the other port during the burst. Data moves on both the rising and the falling edge of `clk`. The falling edge stands for the rising edge of the inverted clock of a complementary pair. A burst therefore takes two clock cycles on each port, and bursts issued every second cycle keep both data buses busy with no idle beat.

One address bus carries both addresses. The read address is presented for the rising edge and the write address for the falling edge of the same cycle. A per-lane mask, sampled with each write beat, protects 9-bit lanes from being written. Writes to the array need no pulse timing from the user. After reset, and again after the system signals that the clock was stopped, the block counts a fixed number of cycles before it raises `ready` and accepts commands.

Top module: `qdr_burst_sram`

## Requirements
- R1: In the cycle after reset is released, `ready` and `rdValid` are both low.
- R2: `ready` rises after exactly RESTORE_CYCLES (default 1024) rising edges of `clk` with `rst` and `clkHalted` low. A rising edge that sees `clkHalted` high clears the count, and `ready` is low after that edge.
- R3: While `ready` is low, `rdSel` and `wrSel` are ignored: no read beats appear and the array is not changed.
- R4: If `rdSel` is high at a rising edge and the command is accepted, the address is taken from `addr` at that edge. The four read beats appear on `rdData` after the falling edge of the next cycle (1.5 cycles of latency), then after the next three edges in turn. `rdValid` is high for exactly those four half-periods.
- R5: Beat k of a burst uses address {a[ADDR_W-1:2], (a[1:0]+k) mod 4}, where a is the burst address. The order is linear and wraps inside the aligned group of four. This holds for reads and for writes.
- R6: If `wrSel` is high at a rising edge and the command is accepted, the write address is taken from `addr` at the following falling edge. The four write beats (`wrData`, `wrMask`) are captured at that falling edge and at the next three edges.
- R7: `wrMask[l]`=1 in a write beat leaves lane l (bits 9l+8..9l) of that word unchanged. `wrMask[l]`=0 writes the lane.
- R8: A read (or write) accepted at one rising edge makes `rdSel` (`wrSel`) at the next rising edge ignored. Commands issued every second cycle give four valid beats per burst with no gap between bursts.
- R9: A read and a write accepted at the same edge, or at overlapping times, both complete with the same timing as when each runs alone.
- R10: Write beats 0 and 1 are stored at the rising edge that captures beat 1, and beats 2 and 3 at the rising edge that captures beat 3. A read beat returns the array contents as they stood just before the edge that drives it. So a read and a write started at the same edge with the same address return the new data in all four beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the falling edge acts as the complementary clock edge |
| rst | input | 1 | Synchronous active-high reset |
| clkHalted | input | 1 | High while the clock has been stopped; restarts the restore count |
| ready | output | 1 | High once the restore count is complete; commands are accepted only then |
| rdSel | input | 1 | Read command, sampled at the rising edge |
| wrSel | input | 1 | Write command, sampled at the rising edge |
| addr | input | ADDR_W | Shared address: read address at the rising edge, write address at the falling edge |
| wrMask | input | LANES | Per-lane write block for each write beat, 1 = keep the old lane |
| wrData | input | 9*LANES | Write data beat, captured on both edges |
| rdData | output | 9*LANES | Read data beat, changing on both edges |
| rdValid | output | 1 | High during the four half-periods of each read burst |

## Verification
The bench goes after the wrap of the burst order when the start offset is not zero. A counter that carried into the upper address bits would read or write the next group and give wrong data on the late beats. It runs read and write bursts back to back and at the same time. A design that dropped beats, stalled one port for the other, or reused a burst address too early would show gaps in `rdValid` or stale words. Reads that overlap a write to the same group are checked beat by beat against the storing edges, which exposes off-by-one-edge visibility. Commands issued while not ready, or in the cycle right after an accepted command, are checked for the absence of read beats and of array changes. A design that did not gate them would corrupt words that are read back later. The restore count is checked edge by edge after reset and after a clock stop, so an off-by-one ready edge is caught.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int unsigned LANE_BITS = 9;

  // strobes from the control to the datapath, one per burst phase
  typedef struct packed {
    logic rdStart;  // read accepted at the last rising edge
    logic rdEarly;  // cycle holding read beats 0 and 1
    logic rdLate;   // cycle holding read beats 2 and 3
    logic wrEarly;  // cycle capturing write beats 0 and 1
    logic wrLate;   // cycle capturing write beats 2 and 3
  } qdr_strobe_t;
endpackage

// File: rtl/qdr_ctrl.sv
module qdr_ctrl
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned RESTORE_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkHalted,
  input  logic              rdSel,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready,
  output qdr_strobe_t       strobe,
  output logic [ADDR_W-1:0] rdBaseA,
  output logic [ADDR_W-1:0] rdBaseB
);
  localparam int unsigned CNT_W = $clog2(RESTORE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(RESTORE_CYCLES);

  logic [CNT_W-1:0] restoreCnt;
  logic rdP1, rdP2, rdP3;
  logic wrP1, wrP2;
  logic rdAccept, wrAccept;

  assign ready    = (restoreCnt == CNT_DONE);
  // one start per port every second cycle, only once restored
  assign rdAccept = rdSel && ready && !rdP1;
  assign wrAccept = wrSel && ready && !wrP1;

  always_ff @(posedge clk) begin
    if (rst) begin
      restoreCnt <= '0;
      rdP1 <= 1'b0;
      rdP2 <= 1'b0;
      rdP3 <= 1'b0;
      wrP1 <= 1'b0;
      wrP2 <= 1'b0;
    end else begin
      if (clkHalted) begin
        restoreCnt <= '0;
      end else if (!ready) begin
        restoreCnt <= restoreCnt + 1'b1;
      end
      rdP1 <= rdAccept;
      rdP2 <= rdP1;
      rdP3 <= rdP2;
      wrP1 <= wrAccept;
      wrP2 <= wrP1;
    end
  end

  // base A serves beats 0/1; base B keeps it one cycle longer for beats 2/3
  always_ff @(posedge clk) begin
    if (rdAccept) begin
      rdBaseA <= addr;
    end
    rdBaseB <= rdBaseA;
  end

  always_comb begin
    strobe.rdStart = rdP1;
    strobe.rdEarly = rdP2;
    strobe.rdLate  = rdP3;
    strobe.wrEarly = wrP1;
    strobe.wrLate  = wrP2;
  end
endmodule

// File: rtl/qdr_datapath.sv
module qdr_datapath
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  qdr_strobe_t                strobe,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ADDR_W-1:0]          rdBaseA,
  input  logic [ADDR_W-1:0]          rdBaseB,
  input  logic [LANES-1:0]           wrMask,
  input  logic [LANES*LANE_BITS-1:0] wrData,
  output logic [LANES*LANE_BITS-1:0] rdData,
  output logic                       rdValid
);
  localparam int unsigned WIDTH = LANES * LANE_BITS;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrBase;
  logic [WIDTH-1:0]  holdData;
  logic [LANES-1:0]  holdMask;
  logic [WIDTH-1:0]  qPos, qNeg;
  logic              vPos, vNeg;
  logic [ADDR_W-1:0] rdAddrNeg, rdAddrPos, wrAddrHold, wrAddrLive;

  // linear step inside the aligned group of four
  function automatic logic [ADDR_W-1:0] beatAddr(input logic [ADDR_W-1:0] base,
                                                 input logic [1:0] step);
    logic [1:0] low;
    low = base[1:0] + step;
    return {base[ADDR_W-1:2], low};
  endfunction

  always_comb begin
    rdAddrNeg  = strobe.rdEarly ? beatAddr(rdBaseA, 2'd0) : beatAddr(rdBaseB, 2'd2);
    rdAddrPos  = strobe.rdEarly ? beatAddr(rdBaseA, 2'd1) : beatAddr(rdBaseB, 2'd3);
    wrAddrHold = strobe.wrEarly ? beatAddr(wrBase, 2'd0) : beatAddr(wrBase, 2'd2);
    wrAddrLive = strobe.wrEarly ? beatAddr(wrBase, 2'd1) : beatAddr(wrBase, 2'd3);
  end

  // complementary edge: write address, even write beats, even read beats
  always_ff @(negedge clk) begin
    if (strobe.wrEarly) begin
      wrBase <= addr;
    end
    holdData <= wrData;
    holdMask <= wrMask;
    qNeg     <= mem[rdAddrNeg];
  end

  always_ff @(negedge clk) begin
    if (rst) vNeg <= 1'b0;
    else     vNeg <= strobe.rdEarly || strobe.rdLate;
  end

  // true edge: odd read beats, and the pair commit of write beats
  always_ff @(posedge clk) begin
    qPos <= mem[rdAddrPos];
    if (strobe.wrEarly || strobe.wrLate) begin
      for (int l = 0; l < LANES; l++) begin
        if (!holdMask[l]) begin
          mem[wrAddrHold][l*LANE_BITS +: LANE_BITS] <= holdData[l*LANE_BITS +: LANE_BITS];
        end
        if (!wrMask[l]) begin
          mem[wrAddrLive][l*LANE_BITS +: LANE_BITS] <= wrData[l*LANE_BITS +: LANE_BITS];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vPos <= 1'b0;
    else     vPos <= strobe.rdEarly || strobe.rdLate;
  end

  // double-rate output: the level of clk picks the half-period register
  assign rdData  = clk ? qPos : qNeg;
  assign rdValid = clk ? vPos : vNeg;
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned LANES          = 2,
  parameter int unsigned RESTORE_CYCLES = 1024
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clkHalted,
  output logic                 ready,
  input  logic                 rdSel,
  input  logic                 wrSel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES-1:0]     wrMask,
  input  logic [LANES*9-1:0]   wrData,
  output logic [LANES*9-1:0]   rdData,
  output logic                 rdValid
);
  qdr_strobe_t       strobe;
  logic [ADDR_W-1:0] rdBaseA, rdBaseB;

  qdr_ctrl #(.ADDR_W(ADDR_W), .RESTORE_CYCLES(RESTORE_CYCLES)) i_ctrl (
    .clk(clk), .rst(rst), .clkHalted(clkHalted), .rdSel(rdSel), .wrSel(wrSel),
    .addr(addr), .ready(ready), .strobe(strobe), .rdBaseA(rdBaseA), .rdBaseB(rdBaseB)
  );

  qdr_datapath #(.ADDR_W(ADDR_W), .LANES(LANES)) i_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .addr(addr), .rdBaseA(rdBaseA),
    .rdBaseB(rdBaseB), .wrMask(wrMask), .wrData(wrData), .rdData(rdData),
    .rdValid(rdValid)
  );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk
  import qdr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        clkHalted,
  input logic        ready,
  input logic        rdValid,
  input qdr_strobe_t strobe
);
  // rdValid seen at a rising edge is the second half-period of the cycle before
  p_ready_holds_r2: assert property (@(posedge clk) disable iff (rst)
    ready && !clkHalted |=> ready);

  p_halt_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
    clkHalted |=> !ready);

  p_ignore_unready_r3: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !strobe.rdStart && !strobe.wrEarly);

  p_read_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.rdStart |=> !strobe.rdStart);

  p_valid_window_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.rdStart |=> rdValid ##1 rdValid);

  p_valid_source_r4: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $past(strobe.rdStart) || $past(strobe.rdStart, 2));
endmodule

bind qdr_burst_sram qdr_burst_sram_chk i_chk (
  .clk(clk), .rst(rst), .clkHalted(clkHalted), .ready(ready),
  .rdValid(rdValid), .strobe(strobe)
);

// File: tb/test_qdr_burst_sram.sv
`timescale 1ns/1ps
module test_qdr_burst_sram;
  localparam int ADDR_W  = 6;
  localparam int LANES   = 2;
  localparam int W       = 18;
  localparam int DEPTH   = 64;
  localparam int RESTORE = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkHalted = 1'b0;
  logic ready, rdSel = 1'b0, wrSel = 1'b0, rdValid;
  logic [ADDR_W-1:0] addr = '0;
  logic [LANES-1:0]  wrMask = '0;
  logic [W-1:0]      wrData = '0;
  logic [W-1:0]      rdData;

  qdr_burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .RESTORE_CYCLES(RESTORE)) i_qdr_burst_sram (
    .clk(clk), .rst(rst), .clkHalted(clkHalted), .ready(ready), .rdSel(rdSel),
    .wrSel(wrSel), .addr(addr), .wrMask(wrMask), .wrData(wrData), .rdData(rdData),
    .rdValid(rdValid)
  );

  always #4 clk = ~clk;  // 125 MHz

  logic [W-1:0]     refMem [DEPTH];
  bit               expOn  [16];
  int               expAddr[16];
  bit               wOn    [16];
  int               wAd    [16];
  logic [W-1:0]     wDat   [16];
  logic [LANES-1:0] wMsk   [16];
  int h = 0;
  int bCnt = 0;
  bit bRdLast = 0, bWrLast = 0;
  bit chkOn = 0;
  int checks = 0, errors = 0;
  string tag = "R1";

  function automatic int bAddr(int base, int k);
    return (base & ~3) | ((base + k) & 3);
  endfunction

  function automatic logic [W-1:0] pat(int a, int k, int gen);
    return W'(a * 613 + k * 97 + gen * 4099 + 5);
  endfunction

  task automatic fail(string what, logic [W-1:0] act, logic [W-1:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
  endtask

  task automatic driveBeat();
    int s = h & 15;
    wrData = wOn[s] ? wDat[s] : W'(h * 7919);
    wrMask = wOn[s] ? wMsk[s] : LANES'(h & 3);
  endtask

  task automatic sampleHalf();
    int s = h & 15;
    if (chkOn) begin
      checks++;
      if (rdValid !== expOn[s]) fail("rdValid", W'(rdValid), W'(expOn[s]));
      else if (expOn[s]) begin
        checks++;
        if (rdData !== refMem[expAddr[s]]) fail("rdData", rdData, refMem[expAddr[s]]);
      end
    end
    expOn[s] = 0;
  endtask

  // R10: pair of beats stored at a rising edge, after that edge's read sample
  task automatic commitPair();
    for (int d = -1; d <= 0; d++) begin
      int s = (h + d) & 15;
      if (wOn[s]) begin
        for (int l = 0; l < LANES; l++)
          if (!wMsk[s][l]) refMem[wAd[s]][l*9 +: 9] = wDat[s][l*9 +: 9];
        wOn[s] = 0;
      end
    end
  endtask

  // one clock cycle, entered and left half way through the low phase
  task automatic step(bit rs, int ra, bit ws, int wa, int gen, int mk);
    bit rdyB, rAcc, wAcc;
    rdyB = (bCnt == RESTORE);
    rAcc = rs && rdyB && !bRdLast && !rst;
    wAcc = ws && rdyB && !bWrLast && !rst;
    rdSel = rs; wrSel = ws; addr = ADDR_W'(ra);
    driveBeat();
    if (rAcc) for (int k = 0; k < 4; k++) begin
      expOn[(h + 3 + k) & 15] = 1;
      expAddr[(h + 3 + k) & 15] = bAddr(ra, k);
    end
    if (wAcc) for (int k = 0; k < 4; k++) begin
      int s = (h + 1 + k) & 15;
      wOn[s] = 1; wAd[s] = bAddr(wa, k);
      wDat[s] = pat(bAddr(wa, k), k, gen);
      wMsk[s] = LANES'((mk >> (2 * k)) & 3);
    end
    @(posedge clk); #1;
    sampleHalf();
    commitPair();
    if (rst || clkHalted) bCnt = 0;
    else if (bCnt < RESTORE) bCnt++;
    bRdLast = rAcc; bWrLast = wAcc;
    if (chkOn) begin
      checks++;
      if (ready !== (bCnt == RESTORE)) fail("ready R2", W'(ready), W'(bCnt == RESTORE));
    end
    h++;
    #1;
    addr = ADDR_W'(wa);
    driveBeat();
    @(negedge clk); #1;
    sampleHalf();
    h++;
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic readAll();
    for (int a = 0; a < DEPTH; a++) begin
      step(1, a, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
    end
    idle(4);
  endtask

  initial begin
    #10;
    idle(3);
    rst = 0;
    chkOn = 1;
    tag = "R1 reset state";
    step(0, 0, 0, 0, 0, 0);
    checks++;
    if (ready !== 1'b0) fail("ready R1", W'(ready), '0);
    checks++;
    if (rdValid !== 1'b0) fail("rdValid R1", W'(rdValid), '0);

    tag = "R2 R3 restore after reset";
    step(1, 5, 1, 9, 7, 0);
    idle(3);
    step(1, 12, 1, 12, 7, 0);
    idle(RESTORE);

    tag = "R6 R5 R8 write fill";
    for (int g = 0; g < 16; g++) begin
      step(0, 0, 1, g * 4 + (g % 4), 1, 0);
      step(0, 0, 0, 0, 0, 0);
    end
    idle(4);
    tag = "R4 R5 R8 read sweep";
    readAll();

    tag = "R7 byte mask";
    for (int g = 0; g < 16; g++) begin
      step(0, 0, 1, g * 4 + ((g + 1) % 4), 2, g * 17);
      step(0, 0, 0, 0, 0, 0);
    end
    idle(4);
    readAll();

    tag = "R8 command spacing";
    step(1, 3, 1, 17, 3, 0);
    step(1, 30, 1, 44, 3, 0);
    step(1, 50, 1, 60, 3, 0);
    step(0, 0, 0, 0, 0, 0);
    idle(4);
    readAll();

    tag = "R9 concurrent ports";
    for (int g = 0; g < 16; g++) begin
      step(1, g * 4 + (g % 4), 1, ((g + 5) % 16) * 4 + 1, 4, 0);
      step(0, 0, 0, 0, 0, 0);
    end
    idle(4);
    readAll();

    tag = "R10 same burst overlap";
    step(1, 20, 1, 20, 5, 0);
    step(0, 0, 0, 0, 0, 0);
    idle(3);
    step(0, 0, 1, 40, 6, 0);
    step(1, 40, 0, 0, 0, 0);
    idle(3);
    step(1, 21, 1, 20, 7, 0);
    step(0, 0, 0, 0, 0, 0);
    idle(3);
    step(1, 46, 1, 45, 8, 0);
    step(0, 0, 0, 0, 0, 0);
    idle(4);

    tag = "R2 R3 clock stop";
    clkHalted = 1;
    step(0, 0, 0, 0, 0, 0);
    step(1, 8, 1, 8, 9, 0);
    idle(2);
    clkHalted = 0;
    step(1, 9, 1, 33, 9, 0);
    idle(RESTORE);
    tag = "R3 array untouched";
    readAll();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule